// File: doc/BRIEF.md
# Strip Restart Marker Recorder

This block records where output strips must restart in a stream of emitted vertices. Each vertex owns one marker bit. A marker is set when an end-of-strip pulse arrives after that vertex has been emitted. The bits are gathered into a 32-bit accumulator. Each full word goes to a header memory through a 128-bit write port. A write places the word into a 128-bit slot chosen by a slot index, and into the 32-bit lanes chosen by a four-bit lane enable.

The header size is the configured maximum vertex count, at one bit per vertex. For a large header, a word is written as soon as it is complete. The word goes out when the vertex that starts the next word is emitted. For a header of 32 bits or fewer, nothing is written until the thread ends. That single word is then copied into all four lanes. At thread end, the word that is still open is always written, provided at least one vertex has been emitted. A point-list output has no strips, so the end-of-strip pulse is ignored in that mode.

The controller has four states:
- **RUN** accepts pulses.
- **FLUSH** holds a mid-stream write until the memory accepts it (FLUSH→RUN on ready).
- **FINAL** holds the thread-end write (FINAL→DONE on ready).
- **DONE** holds until reset.

The transitions out of RUN are:
- RUN→FLUSH on an emit that closes a word.
- RUN→FINAL on thread end with vertices present.
- RUN→DONE on thread end with no vertex.

Top module: `strip_cut_recorder`

## Requirements
- R1: An end-of-strip pulse ORs a one into the accumulator at bit position (count − 1) mod 32, where count is the number of vertices emitted before that cycle. With count 0 this is bit 31.
- R2: When end-of-strip and emit arrive in the same cycle, the marker is applied first. It therefore marks the vertex emitted before that cycle.
- R3: When the maximum exceeds 32, the emit that takes count from 0 to 1 clears the accumulator. Any end-of-strip seen before the first vertex is therefore lost.
- R4: When the maximum exceeds 32, an emit that finds count a non-zero multiple of 32 issues one write and clears the accumulator. The write carries the accumulator, including any marker from the same cycle. Its word index is (count − 1) >> 5. The vertex is then counted.
- R5: The word fills all four 32-bit lanes of wr_data_o. wr_lanes_o is 1 << (index & 3) when the maximum exceeds 32, and 4'b1111 otherwise.
- R6: wr_slot_o is index >> 2 when the maximum exceeds 128, and 0 otherwise. Memory dword address = slot*4 + lane.
- R7: A thread-end pulse issues a final write of the accumulator at index (count − 1) >> 5 if count is non-zero, and no write if count is 0. After it, busy_o stays 1 until reset.
- R8: With a maximum of 32 or fewer, the accumulator starts at 0 and the only write is the one at thread end.
- R9: Emits with count already equal to the maximum are ignored.
- R10: When points_i is 1, end-of-strip pulses have no effect.
- R11: After reset busy_o and wr_valid_o are 0. While wr_valid_o is 1 and wr_ready_i is 0, the payload holds. busy_o is 1 while a write is pending, and pulses are ignored while busy_o is 1.
- R12: A thread-end pulse takes precedence over an emit in the same cycle: the emit is dropped and a same-cycle marker still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| points_i | input | 1 | Static: output is a point list |
| emit_i | input | 1 | Vertex emitted pulse |
| cut_i | input | 1 | End-of-strip pulse |
| end_i | input | 1 | Thread end pulse |
| busy_o | output | 1 | Pulses are not accepted |
| wr_valid_o | output | 1 | Header write pending |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_slot_o | output | SLOT_W | 128-bit slot index |
| wr_lanes_o | output | 4 | 32-bit lane enables |
| wr_data_o | output | 128 | Write data, word in every lane |

## Verification
A pulse sampled at a rising edge in RUN shows its effect one edge later. A write it triggers raises wr_valid_o and busy_o right after that edge. A write accepted at an edge where wr_ready_i is 1 drops wr_valid_o right after that edge. The bench drives at falling edges. Its reference model updates at the same rising edge as the design. Both are compared at the next falling edge, so every result is checked in the first cycle it is due. Ready is toggled in an irregular pattern so that held writes are exercised. Two instances, one with a small header and one with a large header, receive the same pulses. Final memory contents and write counts are checked against hand-computed words.

// File: rtl/cut_pkg.sv
package cut_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_FINAL = 2'd2,
        ST_DONE  = 2'd3
    } cut_state_e;

    // bit that marks the vertex emitted before the current count
    function automatic logic [4:0] prev_bit_pos(input logic [31:0] count);
        logic [31:0] prev;
        prev = count - 32'd1;
        return prev[4:0];
    endfunction

    // header dword that holds the marker of the vertex before count
    function automatic logic [31:0] prev_word_idx(input logic [31:0] count);
        return (count - 32'd1) >> 5;
    endfunction

endpackage

// File: rtl/cut_accum.sv
module cut_accum
    import cut_pkg::*;
#(
    parameter int MAX_VERTS = 256,
    parameter int CNT_W     = $clog2(MAX_VERTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_i,
    input  logic             advance_i,
    input  logic             wipe_i,
    output logic [CNT_W-1:0] count_o,
    output logic [31:0]      word_o
);

    logic [31:0]      acc_q;
    logic [CNT_W-1:0] count_q;

    // accumulator including this cycle's marker
    always_comb begin
        word_o = acc_q;
        if (mark_i)
            word_o = acc_q | (32'd1 << prev_bit_pos(32'(count_q)));
    end

    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            count_q <= '0;
        end else begin
            acc_q <= wipe_i ? 32'd0 : word_o;
            if (advance_i)
                count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cut_wr_port.sv
module cut_wr_port #(
    parameter int SLOT_W    = 1,
    parameter bit USE_LANES = 1'b1,
    parameter bit USE_SLOT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [31:0]       word_i,
    input  logic [31:0]       idx_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [127:0]      data_o,
    output logic [3:0]        lanes_o,
    output logic [SLOT_W-1:0] slot_o
);

    logic [3:0]        lane_sel;
    logic [SLOT_W-1:0] slot_sel;
    logic              unused_idx_bits;

    assign unused_idx_bits = ^idx_i;

    generate
        if (USE_LANES) begin : g_lanes
            assign lane_sel = 4'b0001 << idx_i[1:0];
        end else begin : g_all_lanes
            assign lane_sel = 4'b1111;
        end
        if (USE_SLOT) begin : g_slot
            assign slot_sel = SLOT_W'(idx_i >> 2);
        end else begin : g_no_slot
            assign slot_sel = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            lanes_o <= '0;
            slot_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= {4{word_i}};
            lanes_o <= lane_sel;
            slot_o  <= slot_sel;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/strip_cut_recorder.sv
module strip_cut_recorder
    import cut_pkg::*;
#(
    parameter int MAX_VERTS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  points_i,
    input  logic                  emit_i,
    input  logic                  cut_i,
    input  logic                  end_i,
    output logic                  busy_o,
    output logic                  wr_valid_o,
    input  logic                  wr_ready_i,
    output logic [((((MAX_VERTS + 127) / 128) > 1) ? $clog2((MAX_VERTS + 127) / 128) : 1)-1:0] wr_slot_o,
    output logic [3:0]            wr_lanes_o,
    output logic [127:0]          wr_data_o
);

    localparam int CNT_W     = $clog2(MAX_VERTS + 1);
    localparam int NUM_SLOTS = (MAX_VERTS + 127) / 128;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam bit BIG       = (MAX_VERTS > 32);
    localparam bit HUGE      = (MAX_VERTS > 128);

    cut_state_e       st_q, st_d;
    logic [CNT_W-1:0] count_w;
    logic [31:0]      cnt32;
    logic [31:0]      word_w;
    logic             mark, advance, wipe, load;

    assign cnt32 = 32'(count_w);

    cut_accum #(
        .MAX_VERTS (MAX_VERTS),
        .CNT_W     (CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_i    (mark),
        .advance_i (advance),
        .wipe_i    (wipe),
        .count_o   (count_w),
        .word_o    (word_w)
    );

    cut_wr_port #(
        .SLOT_W    (SLOT_W),
        .USE_LANES (BIG),
        .USE_SLOT  (HUGE)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (word_w),
        .idx_i   (prev_word_idx(cnt32)),
        .ready_i (wr_ready_i),
        .valid_o (wr_valid_o),
        .data_o  (wr_data_o),
        .lanes_o (wr_lanes_o),
        .slot_o  (wr_slot_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    // next state and datapath controls
    always_comb begin
        st_d    = st_q;
        mark    = 1'b0;
        advance = 1'b0;
        wipe    = 1'b0;
        load    = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                mark = cut_i && !points_i;
                if (end_i) begin
                    load = (cnt32 != 32'd0);
                    st_d = load ? ST_FINAL : ST_DONE;
                end else if (emit_i && (cnt32 < 32'(MAX_VERTS))) begin
                    advance = 1'b1;
                    if (BIG && (cnt32[4:0] == 5'd0)) begin
                        wipe = 1'b1;
                        load = (cnt32 != 32'd0);
                    end
                    if (load)
                        st_d = ST_FLUSH;
                end
            end
            ST_FLUSH: if (wr_ready_i) st_d = ST_RUN;
            ST_FINAL: if (wr_ready_i) st_d = ST_DONE;
            ST_DONE:  st_d = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (st_q != ST_RUN);
    end

endmodule

// File: rtl/cut_checker.sv
module cut_checker
    import cut_pkg::*;
#(
    parameter int MAX_VERTS = 256,
    parameter int CNT_W     = 9,
    parameter int SLOT_W    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [127:0]      wr_data,
    input logic [3:0]        wr_lanes,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [CNT_W-1:0]  count,
    input cut_state_e        st
);

    localparam bit BIG  = (MAX_VERTS > 32);
    localparam bit HUGE = (MAX_VERTS > 128);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)
                                     && $stable(wr_lanes) && $stable(wr_slot)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

    assert_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (BIG ? ($countones(wr_lanes) == 1) : (wr_lanes == 4'hF)));

    assert_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data[31:0] == wr_data[63:32]) && (wr_data[31:0] == wr_data[95:64])
                      && (wr_data[31:0] == wr_data[127:96])));

    assert_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !HUGE) |-> (wr_slot == '0));

    assert_no_empty_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !wr_valid);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (st == ST_DONE && busy));

    assert_small_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !BIG) |-> (st == ST_FINAL));

    assert_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= 32'(MAX_VERTS));

endmodule

bind strip_cut_recorder cut_checker #(
    .MAX_VERTS (MAX_VERTS),
    .CNT_W     (CNT_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_o),
    .wr_valid (wr_valid_o),
    .wr_ready (wr_ready_i),
    .wr_data  (wr_data_o),
    .wr_lanes (wr_lanes_o),
    .wr_slot  (wr_slot_o),
    .count    (count_w),
    .st       (st_q)
);

// File: tb/cut_ref_model.sv
module cut_ref_model #(
    parameter int MAXV = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        points,
    input  logic        emit,
    input  logic        cut,
    input  logic        fin_req,
    input  logic        ready,
    output logic        exp_valid,
    output logic        exp_busy,
    output logic [31:0] exp_word,
    output logic [3:0]  exp_lanes,
    output int          exp_slot
);

    int          cnt;
    logic [31:0] acc;
    bit          pend;
    bit          fin;

    task automatic post(input logic [31:0] w, input int c);
        int idx;
        idx = (c - 1) / 32;
        pend = 1;
        exp_word  <= w;
        exp_lanes <= (MAXV > 32) ? (4'b0001 << (idx % 4)) : 4'hF;
        exp_slot  <= (MAXV > 128) ? idx / 4 : 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; acc = 0; pend = 0; fin = 0;
        end else if (pend) begin
            if (ready) pend = 0;
        end else if (!fin) begin
            if (cut && !points)
                acc = acc | (32'd1 << ((cnt + 31) % 32));
            if (fin_req) begin
                if (cnt != 0) post(acc, cnt);
                fin = 1;
            end else if (emit && cnt < MAXV) begin
                if (MAXV > 32 && cnt % 32 == 0) begin
                    if (cnt != 0) post(acc, cnt);
                    acc = 0;
                end
                cnt++;
            end
        end
        exp_valid <= pend;
        exp_busy  <= pend || fin;
    end

endmodule

// File: tb/strip_cut_recorder_test.sv
module strip_cut_recorder_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, points = 1'b0, emit = 1'b0, cut = 1'b0, fin = 1'b0;
    logic ready = 1'b0, mem_clr = 1'b1;
    int   cyc = 0;
    int   tests = 0, fails = 0;

    logic         busy_b, valid_b, busy_s, valid_s;
    logic [0:0]   slot_b, slot_s;
    logic [3:0]   lanes_b, lanes_s;
    logic [127:0] data_b, data_s;

    logic        ev_b, eb_b, ev_s, eb_s;
    logic [31:0] ew_b, ew_s;
    logic [3:0]  el_b, el_s;
    int          es_b, es_s;

    logic [31:0] mem_b [0:7];
    logic [31:0] mem_s [0:3];
    int          wr_cnt_b, wr_cnt_s;

    strip_cut_recorder #(.MAX_VERTS(256)) uut (
        .clk(clk), .rst_n(rst_n), .points_i(points), .emit_i(emit), .cut_i(cut),
        .end_i(fin), .busy_o(busy_b), .wr_valid_o(valid_b), .wr_ready_i(ready),
        .wr_slot_o(slot_b), .wr_lanes_o(lanes_b), .wr_data_o(data_b));

    strip_cut_recorder #(.MAX_VERTS(20)) uut_small (
        .clk(clk), .rst_n(rst_n), .points_i(points), .emit_i(emit), .cut_i(cut),
        .end_i(fin), .busy_o(busy_s), .wr_valid_o(valid_s), .wr_ready_i(ready),
        .wr_slot_o(slot_s), .wr_lanes_o(lanes_s), .wr_data_o(data_s));

    cut_ref_model #(.MAXV(256)) ref_b (
        .clk(clk), .rst_n(rst_n), .points(points), .emit(emit), .cut(cut),
        .fin_req(fin), .ready(ready), .exp_valid(ev_b), .exp_busy(eb_b),
        .exp_word(ew_b), .exp_lanes(el_b), .exp_slot(es_b));

    cut_ref_model #(.MAXV(20)) ref_s (
        .clk(clk), .rst_n(rst_n), .points(points), .emit(emit), .cut(cut),
        .fin_req(fin), .ready(ready), .exp_valid(ev_s), .exp_busy(eb_s),
        .exp_word(ew_s), .exp_lanes(el_s), .exp_slot(es_s));

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // header memory model
    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 8; i++) mem_b[i] <= 32'd0;
            for (int i = 0; i < 4; i++) mem_s[i] <= 32'd0;
            wr_cnt_b <= 0;
            wr_cnt_s <= 0;
        end else begin
            if (valid_b && ready) begin
                wr_cnt_b <= wr_cnt_b + 1;
                for (int l = 0; l < 4; l++)
                    if (lanes_b[l]) mem_b[{slot_b, 2'(l)}] <= data_b[32*l +: 32];
            end
            if (valid_s && ready) begin
                wr_cnt_s <= wr_cnt_s + 1;
                for (int l = 0; l < 4; l++)
                    if (lanes_s[l]) mem_s[l] <= data_s[32*l +: 32];
            end
        end
    end

    // irregular ready pattern
    always @(negedge clk) begin
        cyc <= cyc + 1;
        ready <= (cyc % 3) != 0;
    end

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy_b == eb_b, "R11 busy (large)", 32'(busy_b), 32'(eb_b));
            check(valid_b == ev_b, "R4 write valid (large)", 32'(valid_b), 32'(ev_b));
            check(busy_s == eb_s, "R11 busy (small)", 32'(busy_s), 32'(eb_s));
            check(valid_s == ev_s, "R8 write valid (small)", 32'(valid_s), 32'(ev_s));
            if (valid_b && ev_b) begin
                check(data_b[31:0] == ew_b, "R1 word (large)", data_b[31:0], ew_b);
                check(data_b == {4{data_b[31:0]}}, "R5 lane copy (large)", data_b[127:96], data_b[31:0]);
                check(lanes_b == el_b, "R5 lanes (large)", 32'(lanes_b), 32'(el_b));
                check(32'(slot_b) == 32'(es_b), "R6 slot (large)", 32'(slot_b), 32'(es_b));
            end
            if (valid_s && ev_s) begin
                check(data_s[31:0] == ew_s, "R1 word (small)", data_s[31:0], ew_s);
                check(lanes_s == el_s, "R5 lanes (small)", 32'(lanes_s), 32'(el_s));
                check(32'(slot_s) == 32'(es_s), "R6 slot (small)", 32'(slot_s), 32'(es_s));
            end
        end
    end

    task automatic start(input logic p);
        rst_n = 1'b0; points = p; mem_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; mem_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic op(input logic e, input logic c, input logic d);
        while (busy_b || busy_s) @(negedge clk);
        emit = e; cut = c; fin = d;
        @(negedge clk);
        emit = 1'b0; cut = 1'b0; fin = 1'b0;
    endtask

    task automatic emit_n(input int n);
        for (int k = 0; k < n; k++) op(1'b1, 1'b0, 1'b0);
    endtask

    task automatic settle;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        // scenario A: markers, same-cycle cut, early cut, streaming flushes
        start(1'b0);
        check(busy_b == 1'b0 && valid_b == 1'b0, "R11 reset state", {busy_b, valid_b}, 32'd0);
        op(1'b0, 1'b1, 1'b0);          // cut before any vertex
        emit_n(3);
        op(1'b0, 1'b1, 1'b0);          // marks vertex 2
        emit_n(2);
        op(1'b1, 1'b1, 1'b0);          // marks vertex 4, then counts vertex 5
        emit_n(24);
        op(1'b0, 1'b1, 1'b0);          // marks vertex 29
        emit_n(3);                     // count 33, dword 0 written
        emit_n(108);                   // count 141
        op(1'b0, 1'b1, 1'b0);          // marks vertex 140
        emit_n(9);                     // count 150
        op(1'b0, 1'b0, 1'b1);
        settle();
        check(mem_b[0] == 32'h2000_0014, "R1 R2 R3 R4 dword 0", mem_b[0], 32'h2000_0014);
        check(mem_b[1] == 32'd0, "R4 dword 1", mem_b[1], 32'd0);
        check(mem_b[4] == 32'h0000_1000, "R6 R7 dword 4 in slot 1", mem_b[4], 32'h0000_1000);
        check(mem_b[5] == 32'd0, "R5 lane mask keeps lane 1", mem_b[5], 32'd0);
        check(wr_cnt_b == 5, "R4 R7 write count (large)", 32'(wr_cnt_b), 32'd5);
        check(busy_b == 1'b1, "R7 busy after thread end", 32'(busy_b), 32'd1);
        for (int l = 0; l < 4; l++)
            check(mem_s[l] == 32'h8008_0014, "R8 R5 small word in every lane", mem_s[l], 32'h8008_0014);
        check(wr_cnt_s == 1, "R8 single write (small)", 32'(wr_cnt_s), 32'd1);

        // scenario B: emits beyond the maximum
        start(1'b0);
        emit_n(260);
        op(1'b1, 1'b1, 1'b1);
        settle();
        check(mem_b[7] == 32'h8000_0000, "R9 R5 last dword in lane 3", mem_b[7], 32'h8000_0000);
        check(wr_cnt_b == 8, "R9 write count (large)", 32'(wr_cnt_b), 32'd8);
        check(mem_s[0] == 32'h0008_0000, "R9 small capped count", mem_s[0], 32'h0008_0000);

        // scenario C: point list ignores end-of-strip
        start(1'b1);
        emit_n(3);
        op(1'b0, 1'b1, 1'b0);
        emit_n(30);
        op(1'b0, 1'b0, 1'b1);
        settle();
        check(mem_b[0] == 32'd0, "R10 cut ignored (large)", mem_b[0], 32'd0);
        check(wr_cnt_b == 2, "R10 write count (large)", 32'(wr_cnt_b), 32'd2);
        check(mem_s[2] == 32'd0 && wr_cnt_s == 1, "R10 cut ignored (small)", mem_s[2], 32'd0);

        // scenario D: thread end wins over a same-cycle emit
        start(1'b0);
        emit_n(32);
        op(1'b1, 1'b1, 1'b1);
        settle();
        check(mem_b[0] == 32'h8000_0000, "R12 final word at index 0", mem_b[0], 32'h8000_0000);
        check(wr_cnt_b == 1, "R12 emit dropped, one write", 32'(wr_cnt_b), 32'd1);
        check(mem_s[3] == 32'h0008_0000, "R12 small marker applied", mem_s[3], 32'h0008_0000);

        // scenario E: thread end with no vertex
        start(1'b0);
        op(1'b0, 1'b0, 1'b1);
        settle();
        check(wr_cnt_b == 0 && wr_cnt_s == 0, "R7 no write without vertex",
              32'(wr_cnt_b + wr_cnt_s), 32'd0);
        check(busy_b == 1'b1 && busy_s == 1'b1, "R7 done state busy", {busy_b, busy_s}, 32'd3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired (R11 progress) actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule